// File: doc/BRIEF.md
# Dual-Port Word Memory with Contention, Mailbox and Semaphore Logic

This block is a 4096 x 16 memory that two agents reach through two separate ports, named left and right, sharing one clock. Either port may read or write any word in any cycle. Each port has its own enable, a write/read select, an output enable, two byte-lane enables and a semaphore select. Read data comes back one cycle after the request. A port drives its read bus only when its output enable was high for that read. Lanes that are not enabled, and the whole bus when the port is not driving, read as zero.

Three features let the two agents coordinate. First, a contention flag rises when both ports target the same word in the same cycle. The flag goes to the port that arrived later, and on a true tie it goes to the right port. A flagged port's write is suppressed. Second, two mailbox words near the top of the map raise an interrupt toward the opposite port. Third, eight hardware semaphores act as ownership tokens. A port requests a token by writing 0 to it and releases it by writing 1. Only the owner reads a token as all zeros.

Top module: `dpr_top`

## Requirements
- R1: A write with both lanes enabled stores the word. A later read of that address from either port returns it on the read bus in the cycle after the request.
- R2: Lane enable bit `ub` covers data bits 15:8 and `lb` covers bits 7:0. A write changes only the enabled lanes. A read returns only the enabled lanes and shows zero in the others.
- R3: When a port's enable is low, that port has no effect: it writes nothing, and its read bus and `drive` flag stay low in the next cycle.
- R4: `drive` is high, and the read bus carries data, only in the cycle after a read (memory or semaphore) made with the output enable high. After a read with output enable low, or after a write, the bus is zero.
- R5: Both ports active on the same memory address in the same cycle raises exactly one busy flag. If one port was already on that address in the previous cycle, the newcomer gets busy. If both arrive together, the right port gets busy. A port that stays on the address keeps the flag it had. Different addresses raise no flag.
- R6: A busy port's write is suppressed. Two reads of the same address in the same cycle both return the stored word.
- R7: An unblocked left write to address 0xFFF raises `r_irq` from the next cycle. A right read of 0xFFF clears it. A left read of 0xFFF leaves it set.
- R8: An unblocked right write to address 0xFFE raises `l_irq` from the next cycle. A left read of 0xFFE clears it.
- R9: Semaphore accesses (enable and semaphore select high) use address bits 2:0 as the token index. Writing data bit 0 = 0 to a free token makes the writing port its owner. A semaphore read returns 0x0000 to the owner and 0xFFFF to any other port.
- R10: A request for a token the other port owns is denied. A release (data bit 0 = 1) by a non-owner is ignored. A release by the owner frees the token.
- R11: When both ports request the same free token in the same cycle, the left port becomes its owner.
- R12: After reset the read buses, `drive`, busy and interrupt outputs are low, and all eight tokens are free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write (1) / read (0) |
| l_oe | input | 1 | Left output enable for reads |
| l_ub | input | 1 | Left upper lane enable (bits 15:8) |
| l_lb | input | 1 | Left lower lane enable (bits 7:0) |
| l_sem | input | 1 | Left semaphore select |
| l_addr | input | 12 | Left address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_drive | output | 1 | Left read bus is carrying data |
| l_busy | output | 1 | Left lost same-address arbitration |
| l_irq | output | 1 | Interrupt toward left port |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write (1) / read (0) |
| r_oe | input | 1 | Right output enable for reads |
| r_ub | input | 1 | Right upper lane enable (bits 15:8) |
| r_lb | input | 1 | Right lower lane enable (bits 7:0) |
| r_sem | input | 1 | Right semaphore select |
| r_addr | input | 12 | Right address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_drive | output | 1 | Right read bus is carrying data |
| r_busy | output | 1 | Right lost same-address arbitration |
| r_irq | output | 1 | Interrupt toward right port |

## Verification
Some rules are checked by assertions on every cycle. They are: a shared address yields exactly one busy flag, no flag appears on distinct addresses, each interrupt follows its set and clear events, a token owner keeps the token until it releases it, and the left port wins a tied request. Other behaviour can only be shown by the bench's scenarios. This covers the stored data surviving a full-map sweep, lane merging under every enable combination, a suppressed write leaving the old word in place, and the value each port reads back from every token.

// File: rtl/dpr_pkg.sv
// Shared types and constants for the dual-port memory.
// Assumes one lane is a byte and a word has two lanes.
package dpr_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    // Ownership state of one semaphore token
    typedef enum logic [1:0] {
        SEM_FREE  = 2'd0,
        SEM_LEFT  = 2'd1,
        SEM_RIGHT = 2'd2
    } sem_owner_e;
endpackage

// File: rtl/dpr_arbiter.sv
// Same-address contention arbiter.
// Remembers each port's previous-cycle address and the flag it held. It gives
// busy to the port that arrived later, or to the right port on a tie.
// Assumes the act_* inputs already exclude semaphore accesses.
module dpr_arbiter #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_l,
    input  logic              act_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              busy_l,
    output logic              busy_r
);
    logic              prev_act_l, prev_act_r, prev_busy_l;
    logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
    logic              held_l, held_r, clash;

    // Track what each port touched last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_act_l  <= 1'b0;
            prev_act_r  <= 1'b0;
            prev_addr_l <= '0;
            prev_addr_r <= '0;
            prev_busy_l <= 1'b0;
        end else begin
            prev_act_l  <= act_l;
            prev_act_r  <= act_r;
            prev_addr_l <= addr_l;
            prev_addr_r <= addr_r;
            prev_busy_l <= busy_l;
        end
    end

    // Decide which side loses on a shared address
    always_comb begin
        held_l = prev_act_l && (prev_addr_l == addr_l);
        held_r = prev_act_r && (prev_addr_r == addr_r);
        clash  = act_l && act_r && (addr_l == addr_r);
        busy_l = clash && ((!held_l && held_r) || (held_l && held_r && prev_busy_l));
        busy_r = clash && !busy_l;
    end

    a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (act_l && act_r && addr_l == addr_r) |-> $countones({busy_l, busy_r}) == 1);
    a_r5_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_l != addr_r) |-> !(busy_l || busy_r));
endmodule

// File: rtl/dpr_mem.sv
// Word array with two independent ports and per-lane write enables.
// Reads are registered and return the word as it was before any same-cycle
// write. Assumes the arbiter never lets both ports write the same word.
module dpr_mem #(
    parameter int ADDR_W = 12,
    parameter int LANE_W = dpr_pkg::LANE_W,
    parameter int LANES  = dpr_pkg::LANES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_l,
    input  logic                     re_l,
    input  logic [LANES-1:0]         be_l,
    input  logic [ADDR_W-1:0]        addr_l,
    input  logic [LANE_W*LANES-1:0]  wd_l,
    output logic [LANE_W*LANES-1:0]  q_l,
    input  logic                     we_r,
    input  logic                     re_r,
    input  logic [LANES-1:0]         be_r,
    input  logic [ADDR_W-1:0]        addr_r,
    input  logic [LANE_W*LANES-1:0]  wd_r,
    output logic [LANE_W*LANES-1:0]  q_r
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANE_W * LANES;

    logic [DATA_W-1:0] mem [DEPTH];

    // Lane-wise writes from both ports
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (we_l && be_l[k]) mem[addr_l][k*LANE_W +: LANE_W] <= wd_l[k*LANE_W +: LANE_W];
            if (we_r && be_r[k]) mem[addr_r][k*LANE_W +: LANE_W] <= wd_r[k*LANE_W +: LANE_W];
        end
    end

    // Registered reads, one per port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_l <= '0;
            q_r <= '0;
        end else begin
            if (re_l) q_l <= mem[addr_l];
            if (re_r) q_r <= mem[addr_r];
        end
    end
endmodule

// File: rtl/dpr_mailbox.sv
// Mailbox interrupt flags between the two ports.
// A left write to the top word raises the right interrupt, and a right read of
// it clears that interrupt. The word one below does the same in the other
// direction. When set and clear coincide, set wins. Writes must be unblocked.
module dpr_mailbox #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_l,
    input  logic              rd_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              wr_r,
    input  logic              rd_r,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              irq_l,
    output logic              irq_r
);
    localparam logic [ADDR_W-1:0] BOX_TO_R = '1;
    localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

    logic set_r, clr_r, set_l, clr_l;

    // Decode mailbox events
    always_comb begin
        set_r = wr_l && (addr_l == BOX_TO_R);
        clr_r = rd_r && (addr_r == BOX_TO_R);
        set_l = wr_r && (addr_r == BOX_TO_L);
        clr_l = rd_l && (addr_l == BOX_TO_L);
    end

    // Update interrupt flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_l <= 1'b0;
            irq_r <= 1'b0;
        end else begin
            if (set_r)      irq_r <= 1'b1;
            else if (clr_r) irq_r <= 1'b0;
            if (set_l)      irq_l <= 1'b1;
            else if (clr_l) irq_l <= 1'b0;
        end
    end

    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n) set_r |=> irq_r);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n) (clr_r && !set_r) |=> !irq_r);
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n) set_l |=> irq_l);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n) (clr_l && !set_l) |=> !irq_l);
endmodule

// File: rtl/dpr_sem.sv
// Bank of ownership tokens shared by the two ports.
// Data bit 0 = 0 requests a token and 1 releases it. A request succeeds only
// on a free token, and the left port wins a tied request. A release counts
// only from the owner.
module dpr_sem #(
    parameter int SEM_N = 8,
    localparam int IDX_W = $clog2(SEM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_l,
    input  logic [IDX_W-1:0] idx_l,
    input  logic             bit_l,
    input  logic             wr_r,
    input  logic [IDX_W-1:0] idx_r,
    input  logic             bit_r,
    output logic [SEM_N-1:0] own_l,
    output logic [SEM_N-1:0] own_r
);
    import dpr_pkg::*;

    for (genvar i = 0; i < SEM_N; i++) begin : g_tok
        sem_owner_e st;
        logic req_l, req_r, rel_l, rel_r;

        // Decode this token's requests and releases
        always_comb begin
            req_l = wr_l && (idx_l == IDX_W'(i)) && !bit_l;
            rel_l = wr_l && (idx_l == IDX_W'(i)) &&  bit_l;
            req_r = wr_r && (idx_r == IDX_W'(i)) && !bit_r;
            rel_r = wr_r && (idx_r == IDX_W'(i)) &&  bit_r;
        end

        // Ownership state machine
        always_ff @(posedge clk) begin
            if (!rst_n) st <= SEM_FREE;
            else begin
                case (st)
                    SEM_FREE:  if (req_l) st <= SEM_LEFT;
                               else if (req_r) st <= SEM_RIGHT;
                    SEM_LEFT:  if (rel_l) st <= SEM_FREE;
                    SEM_RIGHT: if (rel_r) st <= SEM_FREE;
                    default:   st <= SEM_FREE;
                endcase
            end
        end

        assign own_l[i] = (st == SEM_LEFT);
        assign own_r[i] = (st == SEM_RIGHT);

        a_r11_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
            (req_l && req_r && !own_l[i] && !own_r[i]) |=> own_l[i]);
        a_r10_keep_left: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && !rel_l) |=> (own_l[i] && !own_r[i]));
        a_r10_keep_right: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r[i] && !rel_r) |=> (own_r[i] && !own_l[i]));
    end
endmodule

// File: rtl/dpr_top.sv
// Dual-port memory with contention flags, mailbox interrupts and semaphores.
// Both ports share one clock. The memory path and the semaphore path are
// chosen per access by the semaphore select. Read data is registered, and the
// lane masking and output enable are applied at the output.
module dpr_top #(
    parameter int ADDR_W = 12,
    parameter int SEM_N  = 8,
    localparam int DATA_W = dpr_pkg::LANE_W * dpr_pkg::LANES,
    localparam int IDX_W  = $clog2(SEM_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic              l_ub,
    input  logic              l_lb,
    input  logic              l_sem,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_drive,
    output logic              l_busy,
    output logic              l_irq,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic              r_ub,
    input  logic              r_lb,
    input  logic              r_sem,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_drive,
    output logic              r_busy,
    output logic              r_irq
);
    import dpr_pkg::*;

    logic act_l, act_r, we_l, we_r, re_l, re_r;
    logic sacc_l, sacc_r;
    logic [LANES-1:0] be_l, be_r;
    logic [DATA_W-1:0] q_l, q_r;
    logic [SEM_N-1:0] own_l, own_r;

    // Classify each port's access this cycle
    always_comb begin
        act_l  = l_en && !l_sem;
        act_r  = r_en && !r_sem;
        sacc_l = l_en && l_sem;
        sacc_r = r_en && r_sem;
        be_l   = {l_ub, l_lb};
        be_r   = {r_ub, r_lb};
        we_l   = act_l && l_wr && !l_busy;
        we_r   = act_r && r_wr && !r_busy;
        re_l   = act_l && !l_wr;
        re_r   = act_r && !r_wr;
    end

    dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .act_l(act_l), .act_r(act_r),
        .addr_l(l_addr), .addr_r(r_addr),
        .busy_l(l_busy), .busy_r(r_busy)
    );

    dpr_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we_l(we_l), .re_l(re_l), .be_l(be_l), .addr_l(l_addr), .wd_l(l_wdata), .q_l(q_l),
        .we_r(we_r), .re_r(re_r), .be_r(be_r), .addr_r(r_addr), .wd_r(r_wdata), .q_r(q_r)
    );

    dpr_mailbox #(.ADDR_W(ADDR_W)) u_mbx (
        .clk(clk), .rst_n(rst_n),
        .wr_l(we_l), .rd_l(re_l), .addr_l(l_addr),
        .wr_r(we_r), .rd_r(re_r), .addr_r(r_addr),
        .irq_l(l_irq), .irq_r(r_irq)
    );

    dpr_sem #(.SEM_N(SEM_N)) u_sem (
        .clk(clk), .rst_n(rst_n),
        .wr_l(sacc_l && l_wr), .idx_l(l_addr[IDX_W-1:0]), .bit_l(l_wdata[0]),
        .wr_r(sacc_r && r_wr), .idx_r(r_addr[IDX_W-1:0]), .bit_r(r_wdata[0]),
        .own_l(own_l), .own_r(own_r)
    );

    // Per-port read return state captured in the request cycle
    logic pend_l, pend_r, fsem_l, fsem_r, sown_l, sown_r, oe_l, oe_r;
    logic [LANES-1:0] bq_l, bq_r;

    // Capture the read context of both ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l <= 1'b0; fsem_l <= 1'b0; sown_l <= 1'b0; oe_l <= 1'b0; bq_l <= '0;
            pend_r <= 1'b0; fsem_r <= 1'b0; sown_r <= 1'b0; oe_r <= 1'b0; bq_r <= '0;
        end else begin
            pend_l <= re_l || (sacc_l && !l_wr);
            fsem_l <= sacc_l;
            sown_l <= own_l[l_addr[IDX_W-1:0]];
            oe_l   <= l_oe;
            bq_l   <= be_l;
            pend_r <= re_r || (sacc_r && !r_wr);
            fsem_r <= sacc_r;
            sown_r <= own_r[r_addr[IDX_W-1:0]];
            oe_r   <= r_oe;
            bq_r   <= be_r;
        end
    end

    logic [DATA_W-1:0] word_l, word_r, mask_l, mask_r;

    // Form the masked output words
    always_comb begin
        word_l = fsem_l ? {DATA_W{!sown_l}} : q_l;
        word_r = fsem_r ? {DATA_W{!sown_r}} : q_r;
        for (int k = 0; k < LANES; k++) begin
            mask_l[k*LANE_W +: LANE_W] = {LANE_W{bq_l[k]}};
            mask_r[k*LANE_W +: LANE_W] = {LANE_W{bq_r[k]}};
        end
        l_drive = pend_l && oe_l;
        r_drive = pend_r && oe_r;
        l_rdata = l_drive ? (word_l & mask_l) : '0;
        r_rdata = r_drive ? (word_r & mask_r) : '0;
    end

    a_r6_blocked_left: assert property (@(posedge clk) disable iff (!rst_n)
        (act_l && act_r && l_addr == r_addr && r_wr) |-> (l_busy || r_busy));
endmodule

// File: tb/tb_dpr_top.sv
module tb_dpr_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en, l_wr, l_oe, l_ub, l_lb, l_sem, r_en, r_wr, r_oe, r_ub, r_lb, r_sem;
    logic [11:0] l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_drive, l_busy, l_irq, r_drive, r_busy, r_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpr_top dut (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb), .l_sem(l_sem),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
        .l_busy(l_busy), .l_irq(l_irq),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb), .r_sem(r_sem),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive),
        .r_busy(r_busy), .r_irq(r_irq)
    );

    function automatic logic [15:0] pat(int a);
        return 16'(a * 947 + 23131);
    endfunction

    function automatic logic [15:0] lanes(logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drv_l(logic en, logic wr, logic sem, logic oe, logic [1:0] be,
                         logic [11:0] a, logic [15:0] d);
        l_en = en; l_wr = wr; l_sem = sem; l_oe = oe; {l_ub, l_lb} = be; l_addr = a; l_wdata = d;
    endtask

    task automatic drv_r(logic en, logic wr, logic sem, logic oe, logic [1:0] be,
                         logic [11:0] a, logic [15:0] d);
        r_en = en; r_wr = wr; r_sem = sem; r_oe = oe; {r_ub, r_lb} = be; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        drv_l(0, 0, 0, 0, 2'b00, 12'h000, 16'h0);
        drv_r(0, 0, 0, 0, 2'b00, 12'h000, 16'h0);
    endtask

    // Read both tokens' view for index i; expected owner code: 0 free, 1 left, 2 right
    task automatic sem_view(string tag, int i, int owner);
        drv_l(1, 0, 1, 1, 2'b11, 12'(i), 16'h0);
        drv_r(1, 0, 1, 1, 2'b11, 12'(i), 16'h0);
        step();
        chk({tag, " left view"},  l_rdata, (owner == 1) ? 16'h0000 : 16'hFFFF);
        chk({tag, " right view"}, r_rdata, (owner == 2) ? 16'h0000 : 16'hFFFF);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 l_rdata", l_rdata, 16'h0);
        chk("R12 r_rdata", r_rdata, 16'h0);
        chk("R12 flags", {12'h0, l_drive, r_drive, l_irq, r_irq}, 16'h0);
        chk("R12 busy", {14'h0, l_busy, r_busy}, 16'h0);
        rst_n = 1'b1;
        step();
        for (int i = 0; i < 8; i++) sem_view("R12 token free", i, 0);

        // R1: fill the whole map from the left, read it all from the right
        for (int a = 0; a < 4096; a++) begin
            drv_l(1, 1, 0, 1, 2'b11, 12'(a), pat(a));
            step();
            if (a == 0) chk("R4 no drive after write", {15'h0, l_drive}, 16'h0);
        end
        idle();
        step();
        chk("R7 irq_r set by left write 0xFFF", {15'h0, r_irq}, 16'h1);
        for (int a = 0; a < 4096; a++) begin
            drv_r(1, 0, 0, 1, 2'b11, 12'(a), 16'h0);
            step();
            chk("R1 right read", r_rdata, pat(a));
        end
        idle();
        step();
        chk("R7 irq_r cleared by right read", {15'h0, r_irq}, 16'h0);
        for (int a = 0; a < 64; a++) begin
            drv_l(1, 0, 0, 1, 2'b11, 12'(a * 61), 16'h0);
            step();
            chk("R1 left read", l_rdata, pat(a * 61));
        end
        idle();

        // R2: lane write and lane read sweep
        for (int a = 0; a < 16; a++) begin
            for (int wb = 0; wb < 4; wb++) begin
                drv_l(1, 1, 0, 1, 2'b11, 12'(a), 16'h1234);
                step();
                drv_l(1, 1, 0, 1, 2'(wb), 12'(a), 16'hABCD);
                step();
                for (int rb = 0; rb < 4; rb++) begin
                    drv_r(1, 0, 0, 1, 2'(rb), 12'(a), 16'h0);
                    step();
                    chk("R2 lanes",
                        r_rdata,
                        ((16'hABCD & lanes(2'(wb))) | (16'h1234 & ~lanes(2'(wb)))) & lanes(2'(rb)));
                end
                drv_r(0, 0, 0, 0, 2'b00, 12'h0, 16'h0);
                idle();
            end
        end

        // R3: disabled port does nothing
        drv_l(0, 1, 0, 1, 2'b11, 12'd100, 16'hDEAD);
        step();
        drv_l(0, 0, 0, 1, 2'b11, 12'd100, 16'h0);
        step();
        chk("R3 disabled read drive", {15'h0, l_drive}, 16'h0);
        chk("R3 disabled read data", l_rdata, 16'h0);
        drv_l(1, 0, 0, 1, 2'b11, 12'd100, 16'h0);
        step();
        chk("R3 disabled write ignored", l_rdata, pat(100));

        // R4: read with output enable low
        drv_l(1, 0, 0, 0, 2'b11, 12'd101, 16'h0);
        step();
        chk("R4 oe low drive", {15'h0, l_drive}, 16'h0);
        chk("R4 oe low data", l_rdata, 16'h0);
        idle();
        step();

        // R5: different addresses, no flag
        drv_l(1, 0, 0, 1, 2'b11, 12'd200, 16'h0);
        drv_r(1, 0, 0, 1, 2'b11, 12'd201, 16'h0);
        #1;
        chk("R5 distinct addr", {14'h0, l_busy, r_busy}, 16'h0);
        step();
        idle();
        step();

        // R5/R6: tie on a write, right loses
        drv_l(1, 1, 0, 1, 2'b11, 12'd300, 16'h1111);
        drv_r(1, 1, 0, 1, 2'b11, 12'd300, 16'h2222);
        #1;
        chk("R5 tie flags", {14'h0, l_busy, r_busy}, 16'h1);
        step();
        idle();
        step();
        drv_l(1, 0, 0, 1, 2'b11, 12'd300, 16'h0);
        step();
        chk("R6 tie write winner", l_rdata, 16'h1111);
        idle();
        step();

        // R5/R6: left arrives later and is blocked
        drv_r(1, 0, 0, 1, 2'b11, 12'd400, 16'h0);
        step();
        drv_l(1, 1, 0, 1, 2'b11, 12'd400, 16'h7777);
        #1;
        chk("R5 newcomer left", {14'h0, l_busy, r_busy}, 16'h2);
        step();
        #1;
        chk("R5 flag kept", {14'h0, l_busy, r_busy}, 16'h2);
        chk("R6 holder read", r_rdata, pat(400));
        step();
        idle();
        step();
        drv_l(1, 0, 0, 1, 2'b11, 12'd400, 16'h0);
        step();
        chk("R6 blocked write", l_rdata, pat(400));
        idle();
        step();

        // R6: both read one word
        drv_l(1, 0, 0, 1, 2'b11, 12'd500, 16'h0);
        drv_r(1, 0, 0, 1, 2'b11, 12'd500, 16'h0);
        step();
        chk("R6 dual read left", l_rdata, pat(500));
        chk("R6 dual read right", r_rdata, pat(500));
        idle();
        step();

        // R8: right to left mailbox
        drv_r(1, 1, 0, 1, 2'b11, 12'hFFE, 16'h0042);
        step();
        idle();
        chk("R8 irq_l set", {15'h0, l_irq}, 16'h1);
        drv_l(1, 0, 0, 1, 2'b11, 12'hFFE, 16'h0);
        step();
        chk("R8 irq_l cleared", {15'h0, l_irq}, 16'h0);
        idle();

        // R7: left read of its own outgoing box does not clear
        drv_l(1, 1, 0, 1, 2'b11, 12'hFFF, 16'h0055);
        step();
        drv_l(1, 0, 0, 1, 2'b11, 12'hFFF, 16'h0);
        step();
        chk("R7 left read keeps irq_r", {15'h0, r_irq}, 16'h1);
        idle();
        drv_r(1, 0, 0, 1, 2'b11, 12'hFFF, 16'h0);
        step();
        chk("R7 right read clears", {15'h0, r_irq}, 16'h0);
        idle();

        // R9: even tokens to left, odd to right
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) drv_l(1, 1, 1, 1, 2'b11, 12'(i), 16'h0);
            else            drv_r(1, 1, 1, 1, 2'b11, 12'(i), 16'h0);
            step();
            idle();
        end
        for (int i = 0; i < 8; i++) sem_view("R9 owner", i, (i % 2 == 0) ? 1 : 2);

        // R10: denial, non-owner release, owner release
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) drv_r(1, 1, 1, 1, 2'b11, 12'(i), 16'h0);
            else            drv_l(1, 1, 1, 1, 2'b11, 12'(i), 16'h0);
            step();
            idle();
            sem_view("R10 denied", i, (i % 2 == 0) ? 1 : 2);
            if (i % 2 == 0) drv_r(1, 1, 1, 1, 2'b11, 12'(i), 16'h1);
            else            drv_l(1, 1, 1, 1, 2'b11, 12'(i), 16'h1);
            step();
            idle();
            sem_view("R10 foreign release", i, (i % 2 == 0) ? 1 : 2);
            if (i % 2 == 0) drv_l(1, 1, 1, 1, 2'b11, 12'(i), 16'h1);
            else            drv_r(1, 1, 1, 1, 2'b11, 12'(i), 16'h1);
            step();
            idle();
            sem_view("R10 owner release", i, 0);
        end

        // R11: tied request goes left
        for (int i = 0; i < 8; i++) begin
            drv_l(1, 1, 1, 1, 2'b11, 12'(i), 16'h0);
            drv_r(1, 1, 1, 1, 2'b11, 12'(i), 16'h0);
            #1;
            chk("R11 no busy on tokens", {14'h0, l_busy, r_busy}, 16'h0);
            step();
            idle();
            sem_view("R11 tie", i, 1);
            drv_l(1, 1, 1, 1, 2'b11, 12'(i), 16'h1);
            step();
            idle();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule